// File: doc/BRIEF.md
# Manchester Word Transmitter with Overrun Guard

This block turns 16-bit words into a 1 Mbit/s Manchester II stream for a dual-redundant serial bus. Every word occupies 20 bit times: a three-bit-time sync whose polarity marks it as a command/status word or a data word, the sixteen data bits with the most significant bit first, and an odd parity bit. Words arrive on a valid/ready stream together with a sync-type flag. The encoded line drives one of two differential output pairs, chosen per word by a bus-select input. The pair that is not chosen stays idle with its transmitter inhibited.

Two guards surround the encoder. A continuous-transmission timer counts how long the transmitter has been active without a break. At 688 µs it latches a shutdown flag, idles both buses and stops taking words until reset. A loopback checker keeps the last word that finished. It compares that word, together with its sync type, against the word a receive decoder hands back. A mismatch, a word that does not come back in time, or a second word that finishes while the first is still unanswered latches a loopback-fail flag.

The bit timing comes from a system clock of 12, 16, 20 or 24 MHz, picked by a two-bit code. The code and the bus select are both sampled when a word is accepted, so a change in the middle of a word has no effect on that word. Back-pressure rule: `in_ready` is high when the transmitter is idle, and also during the final clock of a word's last half-bit. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_data`, `in_cmd_sync`, `rate_sel` and `bus_sel` are sampled only on that edge. A source that keeps `in_valid` high gets its words sent back to back with no gap.

Top module: `manchester_word_tx`

## Requirements
- R1: After reset, all four bus data outputs are high, both inhibits are high, `in_ready` is high, and `tx_shutdown` and `loop_fail` are low. Whenever no word is being sent, every bus data output stays high and both inhibits stay high.
- R2: A word is 40 half-bit slots. The first six slots are the sync: a command/status word (`in_cmd_sync`=1) gives high, high, high, low, low, low, and a data word gives the inverse. Next come the 16 data bits, bit 15 first. The last pair of slots carries the parity bit, chosen so that data plus parity contain an odd number of ones.
- R3: A bit of value 1 is sent as high then low, and a bit of value 0 as low then high. This holds for data and parity. While a bus is driven, its negative output is the complement of its positive output.
- R4: One half-bit slot lasts 6, 8, 10 or 12 clocks for `rate_sel` 00, 01, 10 or 11. That gives one bit per microsecond at 12, 16, 20 or 24 MHz. The code is sampled when the word is accepted.
- R5: The bus chosen at acceptance (`bus_sel` 0 = A, 1 = B) carries the word with its inhibit low. The other bus keeps both outputs high and its inhibit high. The two inhibits are never low together.
- R6: A word is accepted on an edge with `in_valid` and `in_ready` both high. `in_ready` is low during a word, except in the final clock of its last slot. A word accepted in that clock starts in the next clock, so the line has no idle gap.
- R7: After 1376 consecutive half-bit periods of unbroken transmission (688 µs), `tx_shutdown` goes high and stays high until reset. Both buses then idle with their inhibits high, and `in_ready` stays low. Thirty-four back-to-back words, which last 680 µs, do not trip the timer.
- R8: When a word finishes, it and its sync type become the pending loopback reference. A returned word (`rx_valid`) with different data or a different sync type sets `loop_fail`, which stays high until reset. A match leaves `loop_fail` unchanged.
- R9: `loop_fail` is also set if no word returns within 24 bit times (48 half-bit periods) after the pending word finished. It is set as well if another word finishes while one is still pending.
- R10: A returned word that arrives while nothing is pending is ignored and leaves `loop_fail` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12, 16, 20 or 24 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Clock-rate code, sampled at word acceptance |
| bus_sel | input | 1 | Bus for the next word: 0 = A, 1 = B |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 16 | Word to send |
| in_cmd_sync | input | 1 | 1 = command/status sync, 0 = data sync |
| rx_valid | input | 1 | Decoder presents a received word |
| rx_data | input | 16 | Received word |
| rx_cmd_sync | input | 1 | Sync type of the received word |
| bus_a_pos | output | 1 | Bus A positive data |
| bus_a_neg | output | 1 | Bus A negative data |
| bus_a_inh | output | 1 | Bus A transmitter inhibit |
| bus_b_pos | output | 1 | Bus B positive data |
| bus_b_neg | output | 1 | Bus B negative data |
| bus_b_inh | output | 1 | Bus B transmitter inhibit |
| tx_shutdown | output | 1 | Sticky continuous-transmission shutdown |
| loop_fail | output | 1 | Sticky loopback failure |

## Verification
A slot counter or shift register that goes astray shows up on the selected pair within one half-bit. The result is a wrong sync polarity, a bit in the wrong place, or a bad parity pair. Each of these is caught by sampling every slot at its midpoint. A half-bit timer with the wrong length moves every later slot, and a single word at each rate code exposes it. A transmission timer that counts wrongly moves the shutdown edge away from the exact 8256-clock point, and the bench checks both sides of that point. A loopback reference that is stale or lost changes `loop_fail` within one returned word, or at the 24-bit-time deadline, whose two sides are also checked.

// File: rtl/mtxw_pkg.sv
package mtxw_pkg;
  localparam int HALF_W = 4;
  typedef logic [1:0] rate_code_t;

  // clocks per half-bit for a 1 us bit at 12/16/20/24 MHz
  function automatic logic [HALF_W-1:0] half_len_of(rate_code_t code);
    case (code)
      2'b00:   return 4'd6;
      2'b01:   return 4'd8;
      2'b10:   return 4'd10;
      default: return 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/mtxw_bit_timer.sv
module mtxw_bit_timer
  import mtxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);
  logic [HALF_W-1:0] hc;

  assign tick = (hc == half_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hc <= '0;
    else if (restart || tick) hc <= '0;
    else                      hc <= hc + 1'b1;
  end

  // half-bit periods are at least six clocks: two ticks never touch
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/mtxw_serializer.sv
module mtxw_serializer
  import mtxw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_HALVES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              tick,
  input  rate_code_t        rate_sel,
  input  logic              bus_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cmd,
  output logic              restart,
  output logic [HALF_W-1:0] half_len,
  output logic              busy,
  output logic              bus_q,
  output logic              line,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_cmd
);
  localparam int SLOTS     = SYNC_HALVES + 2 * DATA_W + 2;
  localparam int SW        = $clog2(SLOTS);
  localparam int DATA_END  = SYNC_HALVES + 2 * DATA_W;

  logic [SW-1:0]     slot;
  logic [DATA_W-1:0] word_q, sh_q;
  logic              cmd_q, par_q;
  logic              last, accept, in_sync, in_body;

  assign last     = busy & tick & (slot == SW'(SLOTS - 1));
  assign in_ready = ~kill & (~busy | last);
  assign accept   = in_valid & in_ready;
  assign restart  = accept;
  assign done     = last & ~kill;
  assign done_data = word_q;
  assign done_cmd  = cmd_q;

  assign in_sync = (slot < SW'(SYNC_HALVES));
  assign in_body = (slot < SW'(DATA_END));

  // second half of every bit pair sits on an odd slot (SYNC_HALVES is even)
  always_comb begin
    if (in_sync)      line = (slot < SW'(SYNC_HALVES / 2)) ? cmd_q : ~cmd_q;
    else if (in_body) line = sh_q[DATA_W-1] ^ slot[0];
    else              line = par_q ^ slot[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      slot     <= '0;
      word_q   <= '0;
      sh_q     <= '0;
      cmd_q    <= 1'b0;
      par_q    <= 1'b0;
      bus_q    <= 1'b0;
      half_len <= half_len_of(2'b00);
    end else if (kill) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      slot     <= '0;
      word_q   <= in_data;
      sh_q     <= in_data;
      cmd_q    <= in_cmd;
      par_q    <= ~^in_data;
      bus_q    <= bus_sel;
      half_len <= half_len_of(rate_sel);
    end else if (busy && tick) begin
      if (last) busy <= 1'b0;
      else      slot <= slot + 1'b1;
      if (!in_sync && in_body && slot[0]) sh_q <= sh_q << 1;
    end
  end

  p_accept_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  p_no_take_midword_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |-> !in_ready);
endmodule

// File: rtl/mtxw_watchdog.sv
module mtxw_watchdog #(
  parameter int LIMIT_US = 688
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic tick,
  output logic shutdown
);
  localparam int LIMIT = 2 * LIMIT_US;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shutdown <= 1'b0;
    end else begin
      if (!busy)     cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
      if (busy && tick && cnt == CW'(LIMIT - 1)) shutdown <= 1'b1;
    end
  end

  p_shutdown_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/mtxw_loopback.sv
module mtxw_loopback #(
  parameter int DATA_W    = 16,
  parameter int WAIT_BITS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_cmd,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_cmd,
  output logic              fail
);
  localparam int WAIT = 2 * WAIT_BITS;
  localparam int WW   = $clog2(WAIT + 1);

  logic              pend, exp_cmd, differs;
  logic [DATA_W-1:0] exp_data;
  logic [WW-1:0]     wcnt;

  assign differs = (rx_data != exp_data) || (rx_cmd != exp_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      exp_data <= '0;
      exp_cmd  <= 1'b0;
      wcnt     <= '0;
      fail     <= 1'b0;
    end else if (done) begin
      if (pend && (!rx_valid || differs)) fail <= 1'b1;
      pend     <= 1'b1;
      exp_data <= done_data;
      exp_cmd  <= done_cmd;
      wcnt     <= '0;
    end else if (pend && rx_valid) begin
      if (differs) fail <= 1'b1;
      pend <= 1'b0;
    end else if (pend && tick) begin
      if (wcnt == WW'(WAIT - 1)) begin
        fail <= 1'b1;
        pend <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);
  p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (wcnt < WW'(WAIT)));
endmodule

// File: rtl/manchester_word_tx.sv
module manchester_word_tx
  import mtxw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_HALVES = 6,
  parameter int WDOG_US     = 688,
  parameter int LB_WAIT     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              bus_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cmd_sync,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_cmd_sync,
  output logic              bus_a_pos,
  output logic              bus_a_neg,
  output logic              bus_a_inh,
  output logic              bus_b_pos,
  output logic              bus_b_neg,
  output logic              bus_b_inh,
  output logic              tx_shutdown,
  output logic              loop_fail
);
  logic              tick, restart, busy, bus_q, line, done, done_cmd;
  logic [HALF_W-1:0] half_len;
  logic [DATA_W-1:0] done_data;
  logic              drive_a, drive_b;

  mtxw_bit_timer u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .half_len(half_len), .tick(tick)
  );

  mtxw_serializer #(.DATA_W(DATA_W), .SYNC_HALVES(SYNC_HALVES)) u_ser (
    .clk(clk), .rst_n(rst_n), .kill(tx_shutdown), .tick(tick),
    .rate_sel(rate_sel), .bus_sel(bus_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_cmd(in_cmd_sync),
    .restart(restart), .half_len(half_len), .busy(busy), .bus_q(bus_q), .line(line),
    .done(done), .done_data(done_data), .done_cmd(done_cmd)
  );

  mtxw_watchdog #(.LIMIT_US(WDOG_US)) u_wdog (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tick(tick), .shutdown(tx_shutdown)
  );

  mtxw_loopback #(.DATA_W(DATA_W), .WAIT_BITS(LB_WAIT)) u_loop (
    .clk(clk), .rst_n(rst_n), .tick(tick), .done(done),
    .done_data(done_data), .done_cmd(done_cmd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_cmd(rx_cmd_sync), .fail(loop_fail)
  );

  // shutdown idles the line in the same cycle it latches
  assign drive_a = busy & ~tx_shutdown & ~bus_q;
  assign drive_b = busy & ~tx_shutdown &  bus_q;

  assign bus_a_pos = drive_a ?  line : 1'b1;
  assign bus_a_neg = drive_a ? ~line : 1'b1;
  assign bus_a_inh = ~drive_a;
  assign bus_b_pos = drive_b ?  line : 1'b1;
  assign bus_b_neg = drive_b ? ~line : 1'b1;
  assign bus_b_inh = ~drive_b;

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_a_pos && bus_a_neg && bus_b_pos && bus_b_neg && bus_a_inh && bus_b_inh));
  p_one_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_a_inh || bus_b_inh);
  p_pair_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_a_inh |-> (bus_a_pos != bus_a_neg));
  p_pair_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_b_inh |-> (bus_b_pos != bus_b_neg));
  p_quiet_after_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_shutdown |-> (bus_a_inh && bus_b_inh && !in_ready));
endmodule

// File: tb/manchester_word_tx_test.sv
module manchester_word_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'b00;
  logic        bus_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_cmd_sync = 1'b0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_data = '0;
  logic        rx_cmd_sync = 1'b0;
  logic        bus_a_pos, bus_a_neg, bus_a_inh, bus_b_pos, bus_b_neg, bus_b_inh;
  logic        tx_shutdown, loop_fail;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  manchester_word_tx uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bus_sel(bus_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_cmd_sync(in_cmd_sync),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_cmd_sync(rx_cmd_sync),
    .bus_a_pos(bus_a_pos), .bus_a_neg(bus_a_neg), .bus_a_inh(bus_a_inh),
    .bus_b_pos(bus_b_pos), .bus_b_neg(bus_b_neg), .bus_b_inh(bus_b_inh),
    .tx_shutdown(tx_shutdown), .loop_fail(loop_fail)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [39:0] exp_pat(input logic [15:0] d, input logic c);
    logic [39:0] p;
    logic par;
    par = ~^d;
    p[39:37] = {3{c}};
    p[36:34] = {3{~c}};
    for (int i = 0; i < 16; i++) begin
      p[33 - 2*i] = d[15 - i];
      p[32 - 2*i] = ~d[15 - i];
    end
    p[1] = par;
    p[0] = ~par;
    return p;
  endfunction

  task automatic reset_dut();
    rst_n = 1'b0; in_valid = 1'b0; rx_valid = 1'b0; rate_sel = 2'b00; bus_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // sends one word and samples every slot mid-way; returns at the last negedge of the word
  task automatic xmit(input logic [15:0] d, input logic c, input logic [1:0] rs, input logic bs,
                      input string req);
    int half;
    logic [39:0] got;
    int bad_pair, bad_other;
    half = (rs == 2'b00) ? 6 : (rs == 2'b01) ? 8 : (rs == 2'b10) ? 10 : 12;
    bad_pair = 0; bad_other = 0; got = '0;
    @(negedge clk);
    in_data = d; in_cmd_sync = c; rate_sel = rs; bus_sel = bs; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    rate_sel = ~rs; bus_sel = ~bs;  // later changes must not disturb this word
    for (int s = 0; s < 40; s++) begin
      for (int k = 0; k < half; k++) begin
        @(negedge clk);
        if (k == half/2) begin
          got[39 - s] = bs ? bus_b_pos : bus_a_pos;
          if (bs ? (bus_b_neg === bus_b_pos || bus_b_inh !== 1'b0)
                 : (bus_a_neg === bus_a_pos || bus_a_inh !== 1'b0)) bad_pair++;
          if (bs ? !(bus_a_pos && bus_a_neg && bus_a_inh)
                 : !(bus_b_pos && bus_b_neg && bus_b_inh)) bad_other++;
        end
      end
    end
    chk({req, " R2 word pattern"}, 64'(got), 64'(exp_pat(d, c)));
    chk("R3 pair complement and inhibit low", 64'(bad_pair), 64'd0);
    chk("R5 other bus idle and inhibited", 64'(bad_other), 64'd0);
  endtask

  task automatic give_back(input logic [15:0] d, input logic c);
    @(negedge clk);
    rx_data = d; rx_cmd_sync = c; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 a outputs high", 64'({bus_a_pos, bus_a_neg, bus_a_inh}), 64'h7);
    chk("R1 b outputs high", 64'({bus_b_pos, bus_b_neg, bus_b_inh}), 64'h7);
    chk("R1 ready", 64'(in_ready), 64'd1);
    chk("R1 flags clear", 64'({tx_shutdown, loop_fail}), 64'd0);
  endtask

  task automatic t_formats();
    reset_dut();
    xmit(16'hA5C3, 1'b1, 2'b00, 1'b0, "R3 command sync");
    xmit(16'h0000, 1'b0, 2'b00, 1'b0, "R3 data zeros");
    xmit(16'hFFFF, 1'b0, 2'b00, 1'b0, "R3 data ones");
    @(negedge clk);
    chk("R1 idle after word", 64'({bus_a_pos, bus_a_neg, bus_a_inh, bus_b_inh}), 64'hF);
  endtask

  task automatic t_rates();
    reset_dut();
    xmit(16'h1357, 1'b1, 2'b01, 1'b0, "R4 rate 01");
    xmit(16'h8001, 1'b0, 2'b10, 1'b0, "R4 rate 10");
    xmit(16'h7E81, 1'b1, 2'b11, 1'b0, "R4 rate 11");
  endtask

  task automatic t_bus_b();
    reset_dut();
    xmit(16'h3C5A, 1'b1, 2'b00, 1'b1, "R5 bus B");
  endtask

  task automatic t_back_to_back();
    int gap;
    logic rdy_mid, first_slot;
    reset_dut();
    gap = 0; rdy_mid = 1'b1; first_slot = 1'b1;
    @(negedge clk);
    in_data = 16'h0F0F; in_cmd_sync = 1'b1; rate_sel = 2'b00; bus_sel = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    in_data = 16'hF00F; in_cmd_sync = 1'b0;
    for (int n = 1; n <= 480; n++) begin
      @(negedge clk);
      if (n == 241) in_valid = 1'b0;
      if (bus_a_inh) gap++;
      if (n == 100) rdy_mid = in_ready;
      if (n == 244) first_slot = bus_a_pos;
    end
    chk("R6 no gap between words", 64'(gap), 64'd0);
    chk("R6 ready low mid-word", 64'(rdy_mid), 64'd0);
    chk("R2 second word data sync starts low", 64'(first_slot), 64'd0);
    @(negedge clk);
    chk("R6 idle after second word", 64'(bus_a_inh), 64'd1);
  endtask

  task automatic t_loop_match();
    reset_dut();
    xmit(16'h4242, 1'b1, 2'b00, 1'b0, "R8 match");
    repeat (20) @(negedge clk);
    give_back(16'h4242, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 matching loopback keeps flag low", 64'(loop_fail), 64'd0);
    repeat (400) @(negedge clk);
    chk("R8 no late timeout after match", 64'(loop_fail), 64'd0);
  endtask

  task automatic t_loop_mismatch();
    reset_dut();
    xmit(16'h4242, 1'b1, 2'b00, 1'b0, "R8 data diff");
    give_back(16'h4243, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8 data mismatch flags", 64'(loop_fail), 64'd1);
    reset_dut();
    xmit(16'h4242, 1'b1, 2'b00, 1'b0, "R8 sync diff");
    give_back(16'h4242, 1'b0);
    repeat (2) @(negedge clk);
    chk("R8 sync type mismatch flags", 64'(loop_fail), 64'd1);
  endtask

  task automatic t_loop_timeout();
    reset_dut();
    xmit(16'h0101, 1'b0, 2'b00, 1'b0, "R9 timeout");
    repeat (276) @(negedge clk);
    chk("R9 no fail at 23 bit times", 64'(loop_fail), 64'd0);
    repeat (24) @(negedge clk);
    chk("R9 fail at 25 bit times", 64'(loop_fail), 64'd1);
    reset_dut();
    xmit(16'h0101, 1'b0, 2'b00, 1'b0, "R9 overlap first");
    xmit(16'h0202, 1'b0, 2'b00, 1'b0, "R9 overlap second");
    @(negedge clk);
    chk("R9 second word finishing first flags", 64'(loop_fail), 64'd1);
  endtask

  task automatic t_loop_stray();
    reset_dut();
    give_back(16'hDEAD, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 stray returned word ignored", 64'(loop_fail), 64'd0);
    xmit(16'h1111, 1'b0, 2'b00, 1'b0, "R10 after stray");
    give_back(16'h1111, 1'b0);
    repeat (2) @(negedge clk);
    chk("R10 no stale reference", 64'(loop_fail), 64'd0);
  endtask

  task automatic t_wdog_hold();
    reset_dut();
    @(negedge clk);
    in_data = 16'h1234; in_cmd_sync = 1'b0; rate_sel = 2'b00; bus_sel = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    repeat (7921) @(negedge clk);
    in_valid = 1'b0;
    repeat (279) @(negedge clk);
    chk("R7 34 words do not trip", 64'(tx_shutdown), 64'd0);
    chk("R7 line idle after 34 words", 64'(bus_a_inh), 64'd1);
  endtask

  task automatic t_wdog_trip();
    reset_dut();
    @(negedge clk);
    in_data = 16'h1234; in_cmd_sync = 1'b0; rate_sel = 2'b00; bus_sel = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    repeat (8250) @(negedge clk);
    chk("R7 not tripped before 688 us", 64'(tx_shutdown), 64'd0);
    repeat (12) @(negedge clk);
    chk("R7 tripped at 688 us", 64'(tx_shutdown), 64'd1);
    chk("R7 buses idle and inhibited", 64'({bus_a_pos, bus_a_neg, bus_a_inh, bus_b_inh}), 64'hF);
    chk("R7 input refused", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    repeat (50) @(negedge clk);
    chk("R7 shutdown sticky", 64'(tx_shutdown), 64'd1);
  endtask

  initial begin
    t_reset();
    t_formats();
    t_rates();
    t_bus_b();
    t_back_to_back();
    t_loop_match();
    t_loop_mismatch();
    t_loop_timeout();
    t_loop_stray();
    t_wdog_hold();
    t_wdog_trip();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end
endmodule